// File: doc/BRIEF.md
# TV active window generator

This block marks the active picture area of a standard-definition TV raster. A pixel-rate enable (one pulse per 13.5 MHz period) advances a horizontal position counter. Two marker inputs restart the timing. The line marker says that the next pixel period is the first of a new line. The field marker says that the next line is the vertical reference line, the first line of VSYNC. The counter wraps by itself at the line length of the chosen standard: 858 periods for 525-line NTSC and 864 for 625-line PAL.

Software writes four values: the standard select, a horizontal start stored as the true start minus 9, a vertical start counted in lines from the reference line, and a field height stored as the line count minus 1. The block takes these values only at a field marker, so the window never moves partway through a field. The outputs are the active flag, the pixel and line indices inside the window, and a field pulse on the first active pixel. There is no data stream, so every pin is a plain control or status signal with no handshake.

Top module: `tv_active_window`

## Requirements
- R1: While reset is low, and after it until the first field marker, `active`, `field_pulse`, `pix_x` and `line_y` are all 0. The configuration held after reset is NTSC, horizontal start 113, vertical start 18, height 239.
- R2: The horizontal count advances by one on each `pix_en` and wraps to 0 after count 857 when the held standard is NTSC (`pal_sel`=0) or after count 863 when it is PAL (`pal_sel`=1). A PAL line with no markers therefore repeats every 864 pixel periods.
- R3: A `line_mark` sampled with `pix_en` makes the following pixel period horizontal count 0. With start 113 and vertical start 2, the first active pixel comes 2*858+122 pixel periods after a combined line and field marker.
- R4: `active` is high when the horizontal count is in [hstart+9, hstart+9+719] and the line is in the vertical window. The run is 720 pixels, or fewer when the line wraps first.
- R5: Inside the window, `pix_x` equals the horizontal count minus (hstart+9). It is 0 outside the window and is always below 720.
- R6: A `field_mark` sampled with `pix_en` makes the following line number 0. Each line restart (a marker or a wrap) adds one to the line number, and the count stops at its maximum. `line_y` equals the line number minus vstart inside the window and is 0 outside it.
- R7: Exactly height+1 consecutive lines, from line vstart to vstart+height, carry active pixels in each field.
- R8: `pal_sel`, `hstart_cfg`, `vstart_cfg` and `height_cfg` are taken only on a pixel that carries `field_mark`. A change at any other time has no effect until the next field marker.
- R9: `field_pulse` is high for exactly one pixel period per field: the one with `active`=1, `pix_x`=0 and `line_y`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel-rate enable, one per 13.5 MHz period |
| line_mark | input | 1 | Line restart marker, sampled with pix_en |
| field_mark | input | 1 | Field restart marker, sampled with pix_en |
| pal_sel | input | 1 | Standard select: 0 NTSC, 1 PAL |
| hstart_cfg | input | 10 | Horizontal start minus 9 |
| vstart_cfg | input | 9 | Vertical start line from the reference line |
| height_cfg | input | 9 | Active lines per field minus 1 |
| active | output | 1 | Inside the active window |
| pix_x | output | 10 | Pixel index inside the window |
| line_y | output | 9 | Line index inside the window |
| field_pulse | output | 1 | First active pixel of the field |

## Verification
The assertions check these rules on every cycle:
- the horizontal count stays inside the longest line;
- each marker restarts its counter on the next period;
- the held configuration changes only on a field-marker pixel;
- `pix_x` stays below 720 whenever `active` is set;
- the field pulse never lasts two pixel periods in a row.

Only the bench scenarios can show the following:
- the exact position of the window after a marker;
- the 864-period PAL wrap with no line markers;
- a window cut short by the line wrap;
- that a configuration written mid-field leaves the current field's timing unchanged.

// File: rtl/tvw_pkg.sv
`timescale 1ns/1ps
package tvw_pkg;
  localparam int HS_W     = 10;
  localparam int VS_W     = 9;
  localparam int HT_W     = 9;
  localparam int X_W      = 10;
  localparam int ACTIVE_W = 720;
  localparam int H_OFFSET = 9;
  localparam int LEN_525  = 858;
  localparam int LEN_625  = 864;

  typedef struct packed {
    logic            pal;
    logic [HS_W-1:0] hs;
    logic [VS_W-1:0] vs;
    logic [HT_W-1:0] ht;
  } win_cfg_t;

  localparam win_cfg_t CFG_RESET = '{pal: 1'b0, hs: 10'd113, vs: 9'd18, ht: 9'd239};
endpackage

// File: rtl/tvw_shadow.sv
`timescale 1ns/1ps
module tvw_shadow
  import tvw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     take,
  input  win_cfg_t cfg_in,
  output win_cfg_t cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= CFG_RESET;
    else if (take) cfg_q <= cfg_in;
  end

  // R8: the held configuration only moves on a field-marker pixel
  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(cfg_q));
endmodule

// File: rtl/tvw_hcount.sv
`timescale 1ns/1ps
module tvw_hcount #(
  parameter int HCW   = 10,
  parameter int LEN_A = 858,
  parameter int LEN_B = 864
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pix_en,
  input  logic           line_mark,
  input  logic           use_b,
  output logic [HCW-1:0] hcnt,
  output logic           line_adv
);
  localparam int LMAX = (LEN_A > LEN_B) ? LEN_A : LEN_B;
  localparam logic [HCW-1:0] LAST_A = HCW'(LEN_A - 1);
  localparam logic [HCW-1:0] LAST_B = HCW'(LEN_B - 1);
  localparam logic [HCW-1:0] LAST_M = HCW'(LMAX - 1);

  logic [HCW-1:0] last;
  assign last     = use_b ? LAST_B : LAST_A;
  assign line_adv = pix_en && (line_mark || (hcnt >= last));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hcnt <= '0;
    else if (pix_en) hcnt <= line_adv ? '0 : hcnt + 1'b1;
  end

  // R2: count never leaves the longest line
  a_r2_h_bound: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt <= LAST_M);
  // R3: marker restarts the line on the next period
  a_r3_h_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && line_mark) |=> (hcnt == '0));
endmodule

// File: rtl/tvw_vcount.sv
`timescale 1ns/1ps
module tvw_vcount #(
  parameter int VCW = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pix_en,
  input  logic           field_mark,
  input  logic           line_adv,
  output logic [VCW-1:0] vcnt
);
  localparam logic [VCW-1:0] V_TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            vcnt <= V_TOP;
    else if (pix_en && field_mark)         vcnt <= '0;
    else if (line_adv && (vcnt != V_TOP))  vcnt <= vcnt + 1'b1;
  end

  // R6: field marker restarts the line number
  a_r6_v_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && field_mark) |=> (vcnt == '0));
  // R6: line number changes only on a restart event
  a_r6_v_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(vcnt));
endmodule

// File: rtl/tvw_window.sv
`timescale 1ns/1ps
module tvw_window
  import tvw_pkg::*;
#(
  parameter int HCW = 10,
  parameter int VCW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HCW-1:0]  hcnt,
  input  logic [VCW-1:0]  vcnt,
  input  win_cfg_t        cfg,
  output logic            active,
  output logic [X_W-1:0]  pix_x,
  output logic [HT_W-1:0] line_y,
  output logic            field_pulse
);
  localparam int HX = HCW + 2;
  localparam int VX = VCW + 2;

  logic [HX-1:0] h_first, h_end, h_ext, h_off;
  logic [VX-1:0] v_first, v_last, v_ext, v_off;
  logic          h_on, v_on;

  always_comb begin
    h_ext   = HX'(hcnt);
    h_first = HX'(cfg.hs) + HX'(H_OFFSET);
    h_end   = h_first + HX'(ACTIVE_W);
    h_on    = (h_ext >= h_first) && (h_ext < h_end);
    h_off   = h_ext - h_first;
    v_ext   = VX'(vcnt);
    v_first = VX'(cfg.vs);
    v_last  = v_first + VX'(cfg.ht);
    v_on    = (v_ext >= v_first) && (v_ext <= v_last);
    v_off   = v_ext - v_first;
  end

  assign active      = h_on && v_on;
  assign pix_x       = active ? X_W'(h_off) : '0;
  assign line_y      = active ? HT_W'(v_off) : '0;
  assign field_pulse = active && (pix_x == '0) && (line_y == '0);

  // R5: index stays inside the 720-pixel window
  a_r5_x_range: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (pix_x < X_W'(ACTIVE_W)));
endmodule

// File: rtl/tv_active_window.sv
`timescale 1ns/1ps
module tv_active_window
  import tvw_pkg::*;
#(
  parameter int HCW = 10,
  parameter int VCW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pix_en,
  input  logic            line_mark,
  input  logic            field_mark,
  input  logic            pal_sel,
  input  logic [HS_W-1:0] hstart_cfg,
  input  logic [VS_W-1:0] vstart_cfg,
  input  logic [HT_W-1:0] height_cfg,
  output logic            active,
  output logic [X_W-1:0]  pix_x,
  output logic [HT_W-1:0] line_y,
  output logic            field_pulse
);
  win_cfg_t       cfg_in, cfg_q;
  logic           take, line_adv;
  logic [HCW-1:0] hcnt;
  logic [VCW-1:0] vcnt;

  assign take   = pix_en && field_mark;
  assign cfg_in = '{pal: pal_sel, hs: hstart_cfg, vs: vstart_cfg, ht: height_cfg};

  tvw_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .take(take), .cfg_in(cfg_in), .cfg_q(cfg_q)
  );

  tvw_hcount #(.HCW(HCW), .LEN_A(LEN_525), .LEN_B(LEN_625)) u_hcount (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_mark(line_mark),
    .use_b(cfg_q.pal), .hcnt(hcnt), .line_adv(line_adv)
  );

  tvw_vcount #(.VCW(VCW)) u_vcount (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .field_mark(field_mark),
    .line_adv(line_adv), .vcnt(vcnt)
  );

  tvw_window #(.HCW(HCW), .VCW(VCW)) u_window (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt), .cfg(cfg_q),
    .active(active), .pix_x(pix_x), .line_y(line_y), .field_pulse(field_pulse)
  );

  // R9: pulse is gone after one pixel period unless a new field begins
  a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (field_pulse && pix_en && !field_mark) |=> !field_pulse);
  // R1: no window before a field marker has been seen
  a_r1_idle_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (vcnt == '1) |-> !active);
endmodule

// File: tb/test_tv_active_window.sv
`timescale 1ns/1ps
module test_tv_active_window;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0, pix_en = 1'b0, line_mark = 1'b0, field_mark = 1'b0, pal_sel = 1'b0;
  logic [9:0] hstart_cfg = 10'd113;
  logic [8:0] vstart_cfg = 9'd18, height_cfg = 9'd239;
  logic       active, field_pulse;
  logic [9:0] pix_x;
  logic [8:0] line_y;

  tv_active_window i_tv_active_window (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_mark(line_mark),
    .field_mark(field_mark), .pal_sel(pal_sel), .hstart_cfg(hstart_cfg),
    .vstart_cfg(vstart_cfg), .height_cfg(height_cfg), .active(active),
    .pix_x(pix_x), .line_y(line_y), .field_pulse(field_pulse)
  );

  int checks = 0, fails = 0;
  bit cmp_on = 0, prev_act = 0;
  int rise_at = 0;
  int rises[$];
  int runs[$];

  // behavioural reference state
  int mh = 0, mv = 1023, pcount = 0;
  bit m_pal = 0;
  int m_hs = 113, m_vs = 18, m_ht = 239;
  int len;
  bit wrap;

  always @(posedge clk) begin
    if (!rst_n) begin
      mh = 0; mv = 1023; pcount = 0;
      m_pal = 0; m_hs = 113; m_vs = 18; m_ht = 239;
    end else if (pix_en) begin
      len  = m_pal ? 864 : 858;
      wrap = line_mark || (mh >= len - 1);
      mh   = wrap ? 0 : mh + 1;
      if (field_mark) mv = 0;
      else if (wrap && mv < 1023) mv = mv + 1;
      if (field_mark) begin
        m_pal = pal_sel; m_hs = hstart_cfg; m_vs = vstart_cfg; m_ht = height_cfg;
        pcount = 0;
      end else pcount = pcount + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    int hs0, ex, ey;
    bit ea, ef;
    hs0 = m_hs + 9;
    ea  = (mh >= hs0) && (mh < hs0 + 720) && (mv >= m_vs) && (mv <= m_vs + m_ht);
    ex  = ea ? mh - hs0 : 0;
    ey  = ea ? mv - m_vs : 0;
    ef  = ea && ex == 0 && ey == 0;
    chk(active == ea, "R4 active", active, ea);
    chk(pix_x == ex, "R5 pix_x", pix_x, ex);
    chk(line_y == ey, "R6 line_y", line_y, ey);
    chk(field_pulse == ef, "R9 field_pulse", field_pulse, ef);
  endtask

  task automatic step(input bit pe, input bit ls, input bit fm);
    @(negedge clk);
    if (cmp_on) begin
      compare();
      if (active && !prev_act) begin rises.push_back(pcount); rise_at = pcount; end
      if (!active && prev_act) runs.push_back(pcount - rise_at);
      prev_act = active;
    end
    pix_en = pe; line_mark = ls; field_mark = fm;
  endtask

  task automatic pixel(input bit ls, input bit fm);
    step(1, ls, fm);
    step(0, 0, 0);
  endtask

  task automatic pixels(input int n);
    for (int i = 0; i < n; i++) pixel(0, 0);
  endtask

  task automatic clear_log();
    rises.delete(); runs.delete();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(active == 0, "R1 reset active", active, 0);
    chk(pix_x == 0, "R1 reset pix_x", pix_x, 0);
    chk(line_y == 0, "R1 reset line_y", line_y, 0);
    chk(field_pulse == 0, "R1 reset field_pulse", field_pulse, 0);
    rst_n = 1'b1;
    cmp_on = 1;

    // idle after reset: no field marker, stays dark (R1)
    clear_log();
    pixels(1000);
    chk(rises.size() == 0, "R1 dark before field", rises.size(), 0);

    // NTSC, marked lines (R3, R4, R6, R7)
    pal_sel = 0; hstart_cfg = 113; vstart_cfg = 2; height_cfg = 2;
    clear_log();
    pixel(1, 1);
    for (int l = 0; l < 6; l++) begin
      pixels(857);
      pixel(1, 0);
    end
    pixels(300);
    pixel(1, 0);
    pixels(50);
    chk(rises.size() == 3, "R7 line count", rises.size(), 3);
    chk(rises.size() > 0 && rises[0] == 1838, "R3 first pixel", rises.size() > 0 ? rises[0] : -1, 1838);
    chk(rises.size() > 1 && rises[1] - rises[0] == 858, "R6 line spacing", rises.size() > 1 ? rises[1] - rises[0] : -1, 858);
    chk(runs.size() > 0 && runs[0] == 720, "R4 run width", runs.size() > 0 ? runs[0] : -1, 720);

    // PAL free-running, mid-field config change ignored (R2, R8)
    pal_sel = 1; hstart_cfg = 123; vstart_cfg = 1; height_cfg = 1;
    clear_log();
    pixel(1, 1);
    pixels(1200);
    pal_sel = 0; hstart_cfg = 50; vstart_cfg = 0; height_cfg = 5;
    pixels(1500);
    chk(rises.size() == 2, "R7 PAL lines", rises.size(), 2);
    chk(rises.size() > 1 && rises[1] - rises[0] == 864, "R2 PAL wrap", rises.size() > 1 ? rises[1] - rises[0] : -1, 864);
    chk(rises.size() > 1 && rises[1] == 1860, "R8 held start", rises.size() > 1 ? rises[1] : -1, 1860);
    chk(runs.size() > 1 && runs[1] == 720, "R8 held width", runs.size() > 1 ? runs[1] : -1, 720);

    // NTSC window clipped by line wrap (R4, R7)
    pal_sel = 0; hstart_cfg = 200; vstart_cfg = 0; height_cfg = 0;
    clear_log();
    pixel(1, 1);
    pixels(1800);
    chk(rises.size() == 1, "R7 single line", rises.size(), 1);
    chk(runs.size() > 0 && runs[0] == 649, "R4 clipped run", runs.size() > 0 ? runs[0] : -1, 649);

    finish_run();
  end
endmodule